// File: doc/BRIEF.md
# Memory Access Adapter with Wait States

This block connects a 32-bit integer-unit bus master to a plain synchronous word memory. The master presents a request with a read/write flag, an address space identifier, a byte address and a two-bit size code. The adapter decodes the address against two windows: a read-only ROM and a read/write RAM. It then holds off for that window's wait-state count, drives one or two word beats on the memory side, and closes the transfer with a single-cycle acknowledge. An access that cannot be carried out completes at once with an error flag, which the core turns into a fetch or data access trap.

Stores are turned into big-endian byte enables. Byte and halfword data are copied across all lanes. A double-word store becomes two word beats on consecutive cycles. Loads always return one full 32-bit word, whatever size code they carry.

Top module: `mem_access_adapter`

## Requirements
- R1: A read produces exactly one memory beat with byte enables 4'b1111 at the word-aligned address (low two bits cleared). The word the memory returns in that beat appears on `rdata` in the acknowledge cycle, whatever the size code.
- R2: Size code 0 is byte, 1 is halfword, 2 is word and 3 is double-word. Write byte enables are big-endian, and `mem_be[3]` covers bits 31:24. A byte at offset k gives 4'b1000 >> k. A halfword gives 4'b1100 at offset 0 and 4'b0011 at offset 2. A word or double-word gives 4'b1111.
- R3: A byte store puts `req_wdata_first[7:0]` on all four lanes. A halfword store puts `req_wdata_first[15:0]` on both halves. A word store sends `req_wdata_first` unchanged.
- R4: A double-word store makes two beats on consecutive cycles. The first carries `req_wdata_first` (the most significant word) at the address. The second carries `req_wdata_second` at the address plus 4.
- R5: After the request is sampled, the first beat follows after exactly the window's wait-state count of idle cycles. That count is ROM_WS for the ROM window and RAM_WS for the RAM window.
- R6: An access that is not naturally aligned (halfword on an odd address, word not on a multiple of 4, double-word not on a multiple of 8) raises `err` and drives no memory beat.
- R7: An address outside both the ROM window and the RAM window raises `err` and drives no memory beat.
- R8: A write that targets the ROM window raises `err` and leaves memory untouched.
- R9: A faulting access is acknowledged in the first cycle after the request is sampled, with no wait states.
- R10: `ack` is a single-cycle pulse, one per request. `mem_asi` carries the request's address space identifier on every beat.
- R11: While reset is held, `ack` and `mem_en` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request valid, held until ack |
| req_write | input | 1 | 1 = store, 0 = load |
| req_asi | input | 8 | Address space identifier |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | Size code (0 byte, 1 half, 2 word, 3 double) |
| req_wdata_first | input | 32 | Store data; most significant word of a double |
| req_wdata_second | input | 32 | Least significant word of a double store |
| ack | output | 1 | Completion pulse |
| err | output | 1 | Access error, valid with ack |
| rdata | output | 32 | Load word, valid with ack when no error |
| mem_en | output | 1 | Memory beat strobe |
| mem_we | output | 1 | Beat is a write |
| mem_asi | output | 8 | Address space identifier for the beat |
| mem_addr | output | 32 | Word-aligned beat address |
| mem_be | output | 4 | Big-endian byte enables |
| mem_wdata | output | 32 | Beat write data |
| mem_rdata | input | 32 | Memory read word, sampled at the end of a read beat |

## Verification
The assertions assume a master that holds `req` and all request fields steady from the request until `ack`. They also assume that the master drops `req` in the cycle after the acknowledge, so each pulse belongs to exactly one request. The stimulus meets both conditions: every access runs from a single task that sets the fields once, waits for the predicted acknowledge cycle and only then releases `req`. The memory model returns data that is stable across a whole read beat, which is what the read-path checks depend on.

// File: rtl/mem_adapt_pkg.sv
package mem_adapt_pkg;
    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;
    localparam int WS_W   = 8;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_XFER,
        ST_RESP
    } state_e;

    typedef struct packed {
        logic              write;
        logic [7:0]        asi;
        logic [WORD_W-1:0] addr;
        size_e             size;
        logic [WORD_W-1:0] wd_first;
        logic [WORD_W-1:0] wd_second;
    } acc_t;

    typedef struct packed {
        logic            fault;
        logic [WS_W-1:0] waits;
    } route_t;

    function automatic logic misaligned(size_e sz, logic [2:0] lo);
        case (sz)
            SZ_BYTE:  return 1'b0;
            SZ_HALF:  return lo[0];
            SZ_WORD:  return |lo[1:0];
            default:  return |lo;
        endcase
    endfunction
endpackage

// File: rtl/mem_region_decode.sv
module mem_region_decode
    import mem_adapt_pkg::*;
#(
    parameter logic [31:0] ROM_BASE  = 32'h0000_0000,
    parameter logic [31:0] ROM_BYTES = 32'h0008_0000,
    parameter int          ROM_WS    = 2,
    parameter logic [31:0] RAM_BASE  = 32'h0200_0000,
    parameter logic [31:0] RAM_BYTES = 32'h0040_0000,
    parameter int          RAM_WS    = 1
) (
    input  acc_t   acc,
    output route_t route
);
    logic [31:0] rom_off, ram_off;
    logic        in_rom, in_ram, bad_align;

    always_comb begin
        rom_off   = acc.addr - ROM_BASE;
        ram_off   = acc.addr - RAM_BASE;
        in_rom    = rom_off < ROM_BYTES;
        in_ram    = ram_off < RAM_BYTES;
        bad_align = misaligned(acc.size, acc.addr[2:0]);
        route.fault = bad_align || !(in_rom || in_ram) || (in_rom && acc.write);
        route.waits = in_ram ? WS_W'(RAM_WS) : WS_W'(ROM_WS);
    end
endmodule

// File: rtl/mem_lane_former.sv
module mem_lane_former
    import mem_adapt_pkg::*;
(
    input  size_e             size,
    input  logic [1:0]        offset,
    input  logic [WORD_W-1:0] wd,
    output logic [LANES-1:0]  be,
    output logic [WORD_W-1:0] lanes
);
    always_comb begin
        case (size)
            SZ_BYTE: begin
                be    = 4'b1000 >> offset;
                lanes = {LANES{wd[7:0]}};
            end
            SZ_HALF: begin
                be    = offset[1] ? 4'b0011 : 4'b1100;
                lanes = {(LANES/2){wd[15:0]}};
            end
            default: begin
                be    = '1;
                lanes = wd;
            end
        endcase
    end
endmodule

// File: rtl/mem_access_adapter.sv
module mem_access_adapter
    import mem_adapt_pkg::*;
#(
    parameter logic [31:0] ROM_BASE  = 32'h0000_0000,
    parameter logic [31:0] ROM_BYTES = 32'h0008_0000,
    parameter int          ROM_WS    = 2,
    parameter logic [31:0] RAM_BASE  = 32'h0200_0000,
    parameter logic [31:0] RAM_BYTES = 32'h0040_0000,
    parameter int          RAM_WS    = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req,
    input  logic        req_write,
    input  logic [7:0]  req_asi,
    input  logic [31:0] req_addr,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_wdata_first,
    input  logic [31:0] req_wdata_second,
    output logic        ack,
    output logic        err,
    output logic [31:0] rdata,
    output logic        mem_en,
    output logic        mem_we,
    output logic [7:0]  mem_asi,
    output logic [31:0] mem_addr,
    output logic [3:0]  mem_be,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata
);
    acc_t            acc_in, acc_q;
    route_t          route;
    state_e          state;
    logic [WS_W-1:0] cnt;
    logic            beat, err_q;
    logic [31:0]     rdata_q;
    logic [3:0]      lane_be;
    logic [31:0]     lane_data;

    always_comb begin
        acc_in.write     = req_write;
        acc_in.asi       = req_asi;
        acc_in.addr      = req_addr;
        acc_in.size      = size_e'(req_size);
        acc_in.wd_first  = req_wdata_first;
        acc_in.wd_second = req_wdata_second;
    end

    mem_region_decode #(
        .ROM_BASE(ROM_BASE), .ROM_BYTES(ROM_BYTES), .ROM_WS(ROM_WS),
        .RAM_BASE(RAM_BASE), .RAM_BYTES(RAM_BYTES), .RAM_WS(RAM_WS)
    ) u_decode (
        .acc   (acc_in),
        .route (route)
    );

    mem_lane_former u_lanes (
        .size   (acc_q.size),
        .offset (acc_q.addr[1:0]),
        .wd     (acc_q.wd_first),
        .be     (lane_be),
        .lanes  (lane_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            acc_q   <= '0;
            cnt     <= '0;
            beat    <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req) begin
                    acc_q <= acc_in;
                    beat  <= 1'b0;
                    err_q <= route.fault;
                    cnt   <= route.waits;
                    if (route.fault)            state <= ST_RESP;
                    else if (route.waits == '0) state <= ST_XFER;
                    else                        state <= ST_WAIT;
                end
                ST_WAIT: begin
                    cnt <= cnt - 1'b1;
                    if (cnt == WS_W'(1)) state <= ST_XFER;
                end
                ST_XFER: begin
                    if (acc_q.write && acc_q.size == SZ_DWORD && !beat) begin
                        beat <= 1'b1;
                    end else begin
                        state <= ST_RESP;
                        if (!acc_q.write) rdata_q <= mem_rdata;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ack       = (state == ST_RESP);
        err       = ack && err_q;
        rdata     = rdata_q;
        mem_en    = (state == ST_XFER);
        mem_we    = acc_q.write;
        mem_asi   = acc_q.asi;
        mem_addr  = {acc_q.addr[31:3], acc_q.addr[2] | beat, 2'b00};
        mem_be    = acc_q.write ? lane_be : 4'hF;
        mem_wdata = beat ? acc_q.wd_second : lane_data;
    end

    p_read_word_r1: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !mem_we) |-> (mem_be == 4'hF && mem_addr[1:0] == 2'b00));

    p_byte_lane_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_we && acc_q.size == SZ_BYTE) |-> ($countones(mem_be) == 1));

    p_dword_pair_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_we && acc_q.size == SZ_DWORD && !beat)
        |=> (mem_en && mem_addr == $past(mem_addr) + 32'd4));

    p_err_nobeat_r6: assert property (@(posedge clk) disable iff (rst)
        (ack && err) |-> !$past(mem_en));

    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    p_asi_steady_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_en && $past(mem_en)) |-> $stable(mem_asi));
endmodule

// File: tb/tb_mem_access_adapter.sv
`timescale 1ns/1ps
module tb_mem_access_adapter;
    localparam int ROM_WS = 2;
    localparam int RAM_WS = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0, req_write = 1'b0;
    logic [7:0]  req_asi = '0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata_first = '0, req_wdata_second = '0;
    logic        ack, err, mem_en, mem_we;
    logic [31:0] rdata, mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [7:0]  mem_asi;
    logic [3:0]  mem_be;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    mem_access_adapter #(.ROM_WS(ROM_WS), .RAM_WS(RAM_WS)) dut (
        .clk(clk), .rst(rst), .req(req), .req_write(req_write), .req_asi(req_asi),
        .req_addr(req_addr), .req_size(req_size), .req_wdata_first(req_wdata_first),
        .req_wdata_second(req_wdata_second), .ack(ack), .err(err), .rdata(rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_asi(mem_asi), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // memory model seen by the design
    logic [31:0] store [bit [29:0]];
    // reference copy kept by the bench
    logic [31:0] shadow [bit [29:0]];

    function automatic logic [31:0] init_word(bit [29:0] idx);
        return {idx[15:0], ~idx[15:0]} ^ 32'hC3A5_0000;
    endfunction

    function automatic logic [31:0] store_word(bit [29:0] idx);
        return store.exists(idx) ? store[idx] : init_word(idx);
    endfunction

    function automatic logic [31:0] shadow_word(bit [29:0] idx);
        return shadow.exists(idx) ? shadow[idx] : init_word(idx);
    endfunction

    always @(posedge clk) begin
        if (!rst && mem_en && mem_we) begin
            logic [31:0] w;
            w = store_word(mem_addr[31:2]);
            for (int k = 0; k < 4; k++)
                if (mem_be[k]) w[k*8 +: 8] = mem_wdata[k*8 +: 8];
            store[mem_addr[31:2]] = w;
        end
    end

    always @(negedge clk) mem_rdata <= store_word(mem_addr[31:2]);

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            miscompares++;
            $display("FAIL watchdog: run hung (actual %0d cycles, expected < 100000)", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic idle_chk(string tag);
        chk(tag, "ack", {31'd0, ack}, 32'd0);
        chk(tag, "mem_en", {31'd0, mem_en}, 32'd0);
    endtask

    task automatic access(bit wr, logic [7:0] asi, logic [31:0] addr, logic [1:0] sz,
                          logic [31:0] d0, logic [31:0] d1, string tag);
        bit in_rom, in_ram, mis, fault;
        int w, beats;
        logic [3:0]  be;
        logic [31:0] data, a;
        in_rom = addr < 32'h0008_0000;
        in_ram = addr >= 32'h0200_0000 && addr < 32'h0240_0000;
        case (sz)
            2'd0: mis = 1'b0;
            2'd1: mis = addr[0];
            2'd2: mis = addr[1:0] != 2'b00;
            default: mis = addr[2:0] != 3'b000;
        endcase
        fault = mis || !(in_rom || in_ram) || (wr && in_rom);
        w     = in_ram ? RAM_WS : ROM_WS;
        beats = (wr && sz == 2'd3) ? 2 : 1;

        @(negedge clk);
        idle_chk(tag);
        req = 1'b1; req_write = wr; req_asi = asi; req_addr = addr; req_size = sz;
        req_wdata_first = d0; req_wdata_second = d1;

        if (fault) begin
            @(negedge clk);
            chk(tag, "err ack", {30'd0, ack, err}, 32'd3);
            chk(tag, "no beat", {31'd0, mem_en}, 32'd0);
        end else begin
            for (int i = 0; i < w; i++) begin
                @(negedge clk);
                idle_chk({tag, " wait"});
            end
            for (int b = 0; b < beats; b++) begin
                @(negedge clk);
                a = {addr[31:2], 2'b00} + 32'(b * 4);
                chk(tag, "mem_en", {31'd0, mem_en}, 32'd1);
                chk(tag, "mem_we", {31'd0, mem_we}, {31'd0, wr});
                chk(tag, "mem_addr", mem_addr, a);
                chk({tag, " R10"}, "mem_asi", {24'd0, mem_asi}, {24'd0, asi});
                chk(tag, "ack in beat", {31'd0, ack}, 32'd0);
                if (wr) begin
                    case (sz)
                        2'd0: begin be = 4'b1000 >> addr[1:0]; data = {4{d0[7:0]}}; end
                        2'd1: begin be = addr[1] ? 4'b0011 : 4'b1100; data = {2{d0[15:0]}}; end
                        default: begin be = 4'hF; data = (b == 0) ? d0 : d1; end
                    endcase
                    chk(tag, "mem_be", {28'd0, mem_be}, {28'd0, be});
                    chk(tag, "mem_wdata", mem_wdata, data);
                    begin
                        logic [31:0] s;
                        s = shadow_word(a[31:2]);
                        for (int k = 0; k < 4; k++)
                            if (be[k]) s[k*8 +: 8] = data[k*8 +: 8];
                        shadow[a[31:2]] = s;
                    end
                end else begin
                    chk({tag, " R1"}, "mem_be", {28'd0, mem_be}, 32'hF);
                end
            end
            @(negedge clk);
            chk(tag, "ack ok", {30'd0, ack, err}, 32'd2);
            if (!wr) chk({tag, " R1"}, "rdata", rdata, shadow_word(addr[31:2]));
        end
        req = 1'b0;
        @(negedge clk);
        chk({tag, " R10"}, "ack pulse", {31'd0, ack}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11", "ack in reset", {31'd0, ack}, 32'd0);
        chk("R11", "mem_en in reset", {31'd0, mem_en}, 32'd0);
        rst = 1'b0;

        access(1'b0, 8'h09, 32'h0000_0100, 2'd2, '0, '0, "R1 R5 rom read");
        access(1'b0, 8'h0B, 32'h0000_0103, 2'd0, '0, '0, "R1 byte read full word");
        access(1'b1, 8'h0A, 32'h0200_0001, 2'd0, 32'h0000_00AB, '0, "R2 R3 byte");
        access(1'b1, 8'h0A, 32'h0200_0003, 2'd0, 32'h0000_0017, '0, "R2 R3 byte off3");
        access(1'b1, 8'h0A, 32'h0200_0006, 2'd1, 32'h0000_BEEF, '0, "R2 R3 half");
        access(1'b1, 8'h0A, 32'h0200_0008, 2'd2, 32'h1234_5678, '0, "R3 R5 word");
        access(1'b0, 8'h0A, 32'h0200_0000, 2'd2, '0, '0, "R2 readback");
        access(1'b0, 8'h0A, 32'h0200_0004, 2'd1, '0, '0, "R2 readback half");
        access(1'b1, 8'h0C, 32'h0200_0010, 2'd3, 32'hAAAA_0001, 32'h5555_0002, "R4 dword");
        access(1'b0, 8'h0C, 32'h0200_0010, 2'd2, '0, '0, "R4 msw readback");
        access(1'b0, 8'h0C, 32'h0200_0014, 2'd2, '0, '0, "R4 lsw readback");
        access(1'b1, 8'h0A, 32'h0200_0009, 2'd1, 32'h0000_FFFF, '0, "R6 R9 odd half");
        access(1'b0, 8'h0A, 32'h0200_0008, 2'd2, '0, '0, "R6 unchanged");
        access(1'b0, 8'h0A, 32'h0200_0102, 2'd2, '0, '0, "R6 R9 misaligned word read");
        access(1'b1, 8'h0A, 32'h0200_0014, 2'd3, 32'h0, 32'h0, "R6 misaligned dword");
        access(1'b0, 8'h0A, 32'h0200_0014, 2'd2, '0, '0, "R6 dword unchanged");
        access(1'b0, 8'h09, 32'h0100_0000, 2'd2, '0, '0, "R7 R9 unmapped read");
        access(1'b1, 8'h09, 32'h0240_0000, 2'd2, 32'h1, '0, "R7 past ram end");
        access(1'b1, 8'h09, 32'h0000_0200, 2'd2, 32'hDEAD_BEEF, '0, "R8 rom write");
        access(1'b0, 8'h09, 32'h0000_0200, 2'd2, '0, '0, "R8 rom unchanged");
        access(1'b0, 8'hFF, 32'h023F_FFFC, 2'd2, '0, '0, "R5 ram last word");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule